// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

The block is a 16-bit up-counter that runs continuously from a fixed divide-by-four prescaler on the bus clock. An 8-bit CPU reads it through two read-only byte registers, one for the high half and one for the low half. A CPU that reads the high half first and the low half next gets a consistent 16-bit value, because the high-byte read freezes a copy of the low byte. That copy stays in place until the low byte is read.

A rollover from 0xFFFF to 0x0000 sets an overflow flag. The flag drives an interrupt request when the interrupt-enable bit is set, and software clears it by writing an acknowledge bit. A start-enable input keeps the counter and prescaler frozen until the clock source is ready.

The register bus has four byte addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 7 is the interrupt enable. Writing a one to bit 0 acknowledges the overflow. |
| 1 | status | bit 7 is the overflow flag. |
| 2 | count high | high byte of the count. |
| 3 | count low | low byte of the count. |

Read data is combinational from the address. The side effects of a read take place at the clock edge that ends the read cycle.

Top module: `coherent_frc`

## Requirements
- R1: While `run_en` is high, the count goes up by one on every fourth enabled clock edge after reset. The first increment comes on the 4th enabled edge.
- R2: Reset sets the count to 0xFFFC and clears the prescaler, the frozen-low-byte state, the overflow flag and the interrupt enable.
- R3: While `run_en` is low, neither the count nor the prescaler advances.
- R4: Writes to address 2 or address 3 are ignored and leave the count unchanged.
- R5: A read of address 2 returns the high byte of the count. A read of address 3 returns the live low byte when no frozen copy is held.
- R6: A read of address 2 captures the current low byte. The next read of address 3 returns that captured byte and releases it. The first low read after reset returns the live value.
- R7: A read of address 2 made while a captured low byte is already held does not replace that byte.
- R8: A clock edge that moves the count from 0xFFFF to 0x0000 sets the overflow flag, which reads as bit 7 of address 1. The flag is set whether or not the interrupt is enabled.
- R9: `irq` is high exactly when the overflow flag and the interrupt enable (bit 7 of address 0) are both set.
- R10: A write to address 0 with bit 0 set clears the overflow flag. If a rollover happens at the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start enable. The counter and prescaler advance only while it is high. |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two events can fall on the same edge: a rollover setting the overflow flag, and a software acknowledge clearing it. The bench resets the block, runs exactly fifteen enabled edges, and then issues the acknowledge write on the sixteenth edge, which is the rollover edge. It judges the outcome by reading the status register, where the flag must still be set. A second acknowledge, issued with no rollover at the same edge, must then clear the flag. The bench also interleaves high-byte reads with prescaler ticks, so that the frozen low byte and the live low byte differ when the low read arrives.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int PRE_W     = 2;
    localparam logic [CNT_W-1:0] CNT_RESET = 16'hFFFC;
    localparam int BIT_IE    = 7;
    localparam int BIT_ACK   = 0;
    localparam int BIT_OVF   = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_LOW  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rd_high;
        logic rd_low;
        logic wr_ctrl;
    } bus_evt_t;

    function automatic bus_evt_t decode_bus(input logic [ADDR_W-1:0] a,
                                            input logic r, input logic w);
        bus_evt_t e;
        e.rd_high = r && (reg_sel_e'(a) == SEL_HIGH);
        e.rd_low  = r && (reg_sel_e'(a) == SEL_LOW);
        e.wr_ctrl = w && (reg_sel_e'(a) == SEL_CTRL);
        return e;
    endfunction
endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
    parameter int PRE_W = frc_pkg::PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (run_en)
            pre_q <= pre_q + 1'b1;
    end

    assign tick = run_en && (&pre_q);

    assert_pre_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(pre_q));
endmodule

// File: rtl/frc_count.sv
module frc_count #(
    parameter int CNT_W = frc_pkg::CNT_W,
    parameter logic [CNT_W-1:0] RESET_VAL = frc_pkg::CNT_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run_en,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RESET_VAL;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign wrap  = tick && (&cnt_q);

    assert_count_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(cnt_q));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/frc_low_latch.sv
module frc_low_latch #(
    parameter int DATA_W = frc_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] live_low,
    input  logic              rd_high,
    input  logic              rd_low,
    output logic [DATA_W-1:0] low_view
);
    logic              held_q;
    logic [DATA_W-1:0] copy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            copy_q <= '0;
        end else if (rd_low) begin
            held_q <= 1'b0;
        end else if (rd_high && !held_q) begin
            held_q <= 1'b1;
            copy_q <= live_low;
        end
    end

    assign low_view = held_q ? copy_q : live_low;

    assert_copy_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (held_q && !rd_low) |=> (held_q && $stable(copy_q)));
endmodule

// File: rtl/coherent_frc.sv
module coherent_frc
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int HI_LSB = CNT_W - DATA_W;

    bus_evt_t         evt;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] low_view;
    logic             ovf_q;
    logic             ie_q;
    logic             ack;

    assign evt = decode_bus(addr, rd, wr);
    assign ack = evt.wr_ctrl && wdata[BIT_ACK];

    frc_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick)
    );

    frc_count #(.CNT_W(CNT_W), .RESET_VAL(CNT_RESET)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run_en(run_en),
        .count(count), .wrap(wrap)
    );

    frc_low_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst(rst), .live_low(count[DATA_W-1:0]),
        .rd_high(evt.rd_high), .rd_low(evt.rd_low), .low_view(low_view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            ie_q  <= 1'b0;
        end else begin
            if (wrap)
                ovf_q <= 1'b1;
            else if (ack)
                ovf_q <= 1'b0;
            if (evt.wr_ctrl)
                ie_q <= wdata[BIT_IE];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(addr))
            SEL_CTRL: rdata[BIT_IE]  = ie_q;
            SEL_STAT: rdata[BIT_OVF] = ovf_q;
            SEL_HIGH: rdata = count[HI_LSB +: DATA_W];
            SEL_LOW:  rdata = low_view;
            default:  rdata = '0;
        endcase
    end

    assign irq = ovf_q && ie_q;

    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_q);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (ack && !wrap) |=> !ovf_q);
endmodule

// File: tb/test_coherent_frc.sv
module test_coherent_frc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [1:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int fails = 0;

    int          m_edges;
    logic        m_held;
    logic [7:0]  m_copy;
    logic        m_flag;
    logic        m_ie;
    logic [7:0]  last_rd;

    always #4 clk = ~clk;

    coherent_frc i_coherent_frc (
        .clk(clk), .rst(rst), .run_en(run_en), .addr(addr), .rd(rd),
        .wr(wr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [15:0] m_count();
        return 16'((32'hFFFC + m_edges / 4) % 32'h10000);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd = 0; wr = 0; run_en = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_edges = 0; m_held = 0; m_copy = '0; m_flag = 0; m_ie = 0;
    endtask

    task automatic step(input logic r, input logic w, input logic [1:0] a,
                        input logic [7:0] d, input logic run);
        logic [15:0] c;
        logic [7:0]  exp;
        logic        wrap_m;
        string       req;
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d; run_en = run;
        #1;
        c = m_count();
        last_rd = rdata;
        if (r) begin
            case (a)
                2'd0: begin exp = {m_ie, 7'b0};   req = "R9"; end
                2'd1: begin exp = {m_flag, 7'b0}; req = "R8"; end
                2'd2: begin exp = c[15:8];        req = "R5"; end
                default: begin exp = m_held ? m_copy : c[7:0]; req = m_held ? "R6" : "R5"; end
            endcase
            check(req, {8'h0, rdata}, {8'h0, exp});
        end
        check("R9", {15'h0, irq}, {15'h0, m_flag && m_ie});
        wrap_m = run && (m_edges % 4 == 3) && (c == 16'hFFFF);
        if (r && a == 2'd3) m_held = 0;
        else if (r && a == 2'd2 && !m_held) begin m_held = 1; m_copy = c[7:0]; end
        if (wrap_m) m_flag = 1;
        else if (w && a == 2'd0 && d[0]) m_flag = 0;
        if (w && a == 2'd0) m_ie = d[7];
        if (run) m_edges++;
        @(posedge clk);
    endtask

    task automatic idle(input int n, input logic run);
        for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'h00, run);
    endtask

    // {rd, wr, addr[1:0], wdata[7:0], run}
    localparam int NV = 20;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd3, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd2, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd3, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd3, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd2, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd2, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b1, 2'd3, 8'h55, 1'b1},
        {1'b0, 1'b1, 2'd2, 8'hAA, 1'b1},
        {1'b1, 1'b0, 2'd3, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd1, 8'h00, 1'b1}
    };

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();

        // R2: reset state, first low read is live
        step(1, 0, 2'd2, 8'h00, 0); check("R2", {8'h0, last_rd}, 16'h00FF);
        step(1, 0, 2'd3, 8'h00, 0); check("R2", {8'h0, last_rd}, 16'h00FC);
        step(1, 0, 2'd1, 8'h00, 0); check("R2", {8'h0, last_rd}, 16'h0000);
        check("R2", {15'h0, irq}, 16'h0000);

        // R3: no advance with run_en low
        idle(12, 0);
        step(1, 0, 2'd3, 8'h00, 0); check("R3", {8'h0, last_rd}, 16'h00FC);

        // R4: writes to count addresses ignored
        step(0, 1, 2'd2, 8'h12, 0);
        step(0, 1, 2'd3, 8'h34, 0);
        step(1, 0, 2'd2, 8'h00, 0); check("R4", {8'h0, last_rd}, 16'h00FF);
        step(1, 0, 2'd3, 8'h00, 0); check("R4", {8'h0, last_rd}, 16'h00FC);

        // R1: first increment on the 4th enabled edge
        do_reset();
        idle(3, 1);
        step(1, 0, 2'd3, 8'h00, 0); check("R1", {8'h0, last_rd}, 16'h00FC);
        idle(1, 1);
        step(1, 0, 2'd3, 8'h00, 0); check("R1", {8'h0, last_rd}, 16'h00FD);

        // R6 R7: table of latch scenarios
        do_reset();
        for (int i = 0; i < NV; i++)
            step(VEC[i][12], VEC[i][11], VEC[i][10:9], VEC[i][8:1], VEC[i][0]);

        // R7 directed: second high read does not refresh
        do_reset();
        step(1, 0, 2'd2, 8'h00, 1);
        idle(7, 1);
        step(1, 0, 2'd2, 8'h00, 1);
        step(1, 0, 2'd3, 8'h00, 1); check("R7", {8'h0, last_rd}, 16'h00FC);
        step(1, 0, 2'd3, 8'h00, 1); check("R6", {8'h0, last_rd}, 16'h00FE);

        // R8 R9: rollover with interrupt disabled, then enabled
        do_reset();
        idle(16, 1);
        step(1, 0, 2'd1, 8'h00, 0); check("R8", {8'h0, last_rd}, 16'h0080);
        step(1, 0, 2'd2, 8'h00, 0); check("R8", {8'h0, last_rd}, 16'h0000);
        check("R9", {15'h0, irq}, 16'h0000);
        step(0, 1, 2'd0, 8'h80, 0);
        step(1, 0, 2'd0, 8'h00, 0); check("R9", {15'h0, irq}, 16'h0001);
        check("R9", {8'h0, last_rd}, 16'h0080);

        // R10: acknowledge clears
        step(0, 1, 2'd0, 8'h81, 0);
        step(1, 0, 2'd1, 8'h00, 0); check("R10", {8'h0, last_rd}, 16'h0000);
        check("R10", {15'h0, irq}, 16'h0000);

        // R10: acknowledge on the rollover edge loses
        do_reset();
        idle(15, 1);
        step(0, 1, 2'd0, 8'h01, 1);
        step(1, 0, 2'd1, 8'h00, 0); check("R10", {8'h0, last_rd}, 16'h0080);
        step(0, 1, 2'd0, 8'h01, 0);
        step(1, 0, 2'd1, 8'h00, 0); check("R10", {8'h0, last_rd}, 16'h0000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule